// File: doc/BRIEF.md
# Handshaked Bus Read Master

This block turns a one-cycle read request from a core into a fully interlocked four-phase read cycle on a bus whose slaves answer at their own pace. When it is idle it takes a request and its address. It puts the address on the bus and holds it for a configurable number of setup cycles. It then raises the address strobe and, one cycle later, the data strobe. The read/write line stays high, meaning read, for the whole cycle.

The master waits in place for as long as the slave leaves its acknowledge low. The acknowledge passes through a two-flop synchronizer before the master uses it. When the synchronized acknowledge is seen high, the master captures the data bus and drops both strobes. The cycle ends, with a one-cycle done pulse, only after the acknowledge has gone low again. A timeout counter caps the wait. If it expires, the strobes are dropped and done is pulsed together with an error flag. A busy output is high for the whole cycle, and requests made while it is high are ignored.

Top module: `async_rd_master`

## Requirements
- R1: While busy, the bus address output equals the address accepted with the request and does not change, and the read/write output is high (1 = read).
- R2: After a request is accepted, both strobes stay low for SETUP_CYC cycles. The address strobe then rises alone for one cycle before the data strobe rises.
- R3: The data strobe stays high, with the address strobe, until the acknowledge has been seen high through a two-flop synchronizer. Both strobes then fall on the third rising edge after the acknowledge input rises.
- R4: The read data output takes the value of the data bus at the edge where the synchronized acknowledge is seen high, and holds it until the next capture.
- R5: After the strobes fall, done pulses for exactly one cycle. The pulse comes only once the synchronized acknowledge is seen low, so a slave that holds its acknowledge delays done.
- R6: If the synchronized acknowledge is not seen within TIMEOUT cycles of the data strobe rising, both strobes fall and done and err pulse together for one cycle. err is never high without done.
- R7: busy is high from the cycle after a request is accepted until the cycle in which done pulses. A request made while busy is ignored. Strobes are low whenever busy is low.
- R8: After reset, busy, both strobes, done, err and the read data output are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request from the core, sampled when idle |
| addr_i | input | AW | Read address from the core |
| busy_o | output | 1 | A bus cycle is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with done_o |
| rdata_o | output | DW | Captured read data |
| bus_addr_o | output | AW | Bus address lines |
| bus_as_o | output | 1 | Address strobe, active high |
| bus_ds_o | output | 1 | Data strobe, active high |
| bus_rw_o | output | 1 | Read/write line, 1 = read |
| bus_ack_i | input | 1 | Slave data acknowledge, asynchronous |
| bus_data_i | input | DW | Bus data lines |

## Verification
The assertions assume that the slave keeps the data bus stable from the moment it raises acknowledge until the master drops its data strobe. They also assume that acknowledge rises only in answer to a data strobe. The bench's slave responder follows both rules. It drives data and acknowledge together, on falling clock edges, with latencies from zero to several cycles and with hold times before release. For the timeout case it keeps acknowledge low the whole time. A request line held high across whole cycles tests that requests made while busy are ignored.

// File: rtl/async_rd_master.sv
module async_rd_master #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int TIMEOUT   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_as_o,
  output logic          bus_ds_o,
  output logic          bus_rw_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_data_i
);
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_AS, S_WAIT, S_REL} st_t;

  st_t           st;
  logic [SW-1:0] scnt;
  logic [TW-1:0] tcnt;
  logic [AW-1:0] addr_q;
  logic          ack_m, ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= bus_ack_i;
      ack_s <= ack_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      scnt    <= '0;
      tcnt    <= '0;
      addr_q  <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        S_IDLE: if (req_i) begin
          addr_q <= addr_i;
          scnt   <= '0;
          st     <= S_SETUP;
        end
        S_SETUP: begin
          if (scnt == SW'(SETUP_CYC - 1)) st <= S_AS;
          else scnt <= scnt + 1'b1;
        end
        S_AS: begin
          tcnt <= '0;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if (ack_s) begin
            rdata_o <= bus_data_i;
            st      <= S_REL;
          end else if (tcnt == TW'(TIMEOUT - 1)) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            st     <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_REL: if (!ack_s) begin
          done_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (st != S_IDLE);
  assign bus_as_o   = (st == S_AS) || (st == S_WAIT);
  assign bus_ds_o   = (st == S_WAIT);
  assign bus_rw_o   = 1'b1;
  assign bus_addr_o = addr_q;

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));

  // R2
  as_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_o) |-> (!bus_ds_o && $past(busy_o)));

  // R3
  ds_needs_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ds_o |-> bus_as_o);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (done_o && !bus_ds_o));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bus_as_o && !bus_ds_o));
endmodule

// File: tb/async_rd_master_tb_top.sv
module async_rd_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 8, SETUP_CYC = 2, TIMEOUT = 16;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, ack = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic busy, done, err, as_o, ds_o, rw_o;
  logic [DW-1:0] rdata;
  logic [AW-1:0] baddr;

  int tests = 0, fails = 0;
  int resp_en = 1, lat = 0, hold = 0, rcnt = 0, hcnt = 0;
  int cyc = 0, ack_rise_cyc = -1, strobe_fall_cyc = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_rd_master #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .TIMEOUT(TIMEOUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .bus_addr_o(baddr), .bus_as_o(as_o), .bus_ds_o(ds_o), .bus_rw_o(rw_o),
    .bus_ack_i(ack), .bus_data_i(data));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 idle,1 setup,2 as,3 wait,4 release
  int ph = 0, sc = 0, tc = 0, a1 = 0, a2 = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_rdata = '0;
  logic m_done = 0, m_err = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ph = 0; sc = 0; tc = 0; a1 = 0; a2 = 0;
      m_addr = '0; m_rdata = '0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (ph == 0) begin
        if (req) begin m_addr = addr; sc = 0; ph = 1; end
      end else if (ph == 1) begin
        sc++;
        if (sc == SETUP_CYC) ph = 2;
      end else if (ph == 2) begin
        tc = 0; ph = 3;
      end else if (ph == 3) begin
        if (a2 != 0) begin m_rdata = data; ph = 4; end
        else begin
          tc++;
          if (tc == TIMEOUT) begin m_done = 1; m_err = 1; ph = 0; end
        end
      end else begin
        if (a2 == 0) begin m_done = 1; ph = 0; end
      end
      a2 = a1; a1 = int'(ack);
    end
  end

  // slave responder, driven on falling edges
  always @(negedge clk) begin
    if (rst_n && resp_en != 0) begin
      if (ds_o && !ack) begin
        if (rcnt >= lat) begin
          ack <= 1'b1; data <= baddr[7:0] ^ 8'h5a; ack_rise_cyc <= cyc;
        end
        rcnt <= rcnt + 1;
      end else if (!ds_o && ack) begin
        if (hcnt >= hold) begin ack <= 1'b0; hcnt <= 0; end
        else hcnt <= hcnt + 1;
        rcnt <= 0;
      end else if (!ds_o) rcnt <= 0;
    end
  end

  // per-cycle comparison against the reference
  logic prev_ds = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 busy", busy, ph != 0);
      chk("R2 as", as_o, ph == 2 || ph == 3);
      chk("R3 ds", ds_o, ph == 3);
      chk("R5 done", done, m_done);
      chk("R6 err", err, m_err);
      chk("R4 rdata", rdata, m_rdata);
      if (busy) begin
        chk("R1 addr", baddr, m_addr);
        chk("R1 rw", rw_o, 1'b1);
      end
      if (prev_ds && !ds_o && !err && ack_rise_cyc >= 0) begin
        chk("R3 fall latency", cyc - ack_rise_cyc, 3);
        ack_rise_cyc = -1;
      end
      prev_ds = ds_o;
    end
  end

  task automatic do_read(logic [AW-1:0] a, int l, int h);
    lat = l; hold = h;
    addr = a; req = 1'b1;
    @(negedge clk); req = 1'b0; addr = '1;
    while (!done) @(negedge clk);
    chk("R4 read value", rdata, (a[7:0] ^ 8'h5a));
    chk("R6 no err on ack", err, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8
    chk("R8 busy", busy, 0); chk("R8 as", as_o, 0); chk("R8 ds", ds_o, 0);
    chk("R8 done", done, 0); chk("R8 err", err, 0); chk("R8 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(16'h1234, 0, 0);
    do_read(16'h00a5, 1, 0);
    do_read(16'hbeef, 5, 0);
    do_read(16'h5a5a, 0, 0);   // data 00 is still valid data
    do_read(16'h7f01, 2, 6);   // slave holds ack: done delayed (R5)
    // R7: request held high across a whole cycle
    lat = 3; hold = 0; addr = 16'h0c3c; req = 1'b1;
    @(negedge clk); addr = 16'hffff;
    repeat (4) @(negedge clk);
    chk("R7 busy ignores req", baddr, 16'h0c3c);
    req = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    // R6: timeout with silent slave
    resp_en = 0;
    addr = 16'h4444; req = 1'b1;
    @(negedge clk); req = 1'b0;
    while (!done) @(negedge clk);
    chk("R6 timeout err", err, 1'b1);
    chk("R6 strobes low", {as_o, ds_o}, 2'b00);
    @(negedge clk);
    chk("R6 err one cycle", err, 1'b0);
    resp_en = 1;
    do_read(16'h0101, 1, 1);
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule